// File: doc/BRIEF.md
# Per-Window Programmable Page Mapper

The block translates a 64 KB processor address space into pages of a larger physical memory. The space is cut into four 16 KB windows. For each window the block presents a physical page number, a flag that says whether that page lives in ROM or RAM, and a write-enable. A bank of eight slot registers holds the window settings, arranged as two groups of four. Bit 4 of a legacy paging byte chooses which group drives the windows. Every slot carries a 2-bit mode and an 8-bit page value. The mode says whether the window sees ROM or RAM. It also says whether the page is taken from the slot as written or merged with the legacy byte's low bits or with the DOS flag.

A small control register holds two bits. One is a global paging enable. The other lets the DOS flag follow an external request line. After reset, paging is off, so every window shows the last ROM page and the processor starts from ROM. A two-state machine tracks paging: `MS_BOOT` means paging is off and `MS_PAGED` means it is on. The transition `T_ENABLE` moves from `MS_BOOT` to `MS_PAGED` on a control write whose enable bit is 1. The transition `T_DISABLE` moves back on a control write whose enable bit is 0. Register writes are synchronous. The outputs follow the register state combinationally.

Top module: `page_mapper`

## Requirements
- R1: After reset, all eight slot registers and the legacy byte are zero. The control bits are zero and the machine is in `MS_BOOT`.
- R2: While paging is off, every window shows page `2**ROM_PAGE_BITS-1`, flagged as ROM, with its write-enable low. Slot contents have no effect.
- R3: Window w (0..3) is driven by slot w when legacy bit 4 is 0, and by slot w+4 when legacy bit 4 is 1.
- R4: Mode 00 (slot data bits 9:8) selects RAM. The page is the legacy byte's bits 2:0 ORed with the slot page ANDed with 0xF8.
- R5: Mode 01 selects ROM. The page is the slot page ANDed with 0xFE, plus 1 when the DOS flag is active.
- R6: Mode 10 selects RAM, and the page is the full slot page.
- R7: Mode 11 selects ROM, and the page is the full slot page.
- R8: The DOS flag is forced active while control bit 1 is 0. While control bit 1 is 1, the flag equals input `dos_req`.
- R9: A window flagged as ROM always has its write-enable low. A RAM window has its write-enable high.
- R10: RAM pages are masked to `RAM_PAGE_BITS` bits and ROM pages to `ROM_PAGE_BITS` bits before output.
- R11: A register changes only on a clock edge where its write strobe is high. Data presented without its strobe leaves the outputs unchanged.
- R12: Control bit 0 is the paging enable. A control write moves the machine to `MS_PAGED` when that bit is 1 and to `MS_BOOT` when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_wr | input | 1 | Write strobe for a slot register |
| slot_idx | input | 3 | Slot number to write (0..7) |
| slot_wdata | input | 10 | Slot data: mode in bits 9:8, page in bits 7:0 |
| leg_wr | input | 1 | Write strobe for the legacy paging byte |
| leg_wdata | input | 8 | Legacy byte: bits 2:0 are RAM bits, bit 4 is the group select |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 2 | Bit 0 is paging enable; bit 1 lets DOS follow `dos_req` |
| dos_req | input | 1 | External DOS request, used when control bit 1 is 1 |
| win_page | output | 32 | Physical page per window; window w is in bits 8w+7:8w |
| win_rom | output | 4 | 1 = the window maps to ROM |
| win_we | output | 4 | 1 = writes to the window are allowed |

## Verification
Every output is combinational from the registers and from `dos_req`. A register write takes effect from the rising edge that samples its strobe. The new mapping can therefore be read in the same cycle, after that edge. The bench applies each write across one rising edge and compares all four windows at the following falling edge. A change on `dos_req` alone has no clock step, so it is compared after a short settling delay. Paging off and paging on are swept across all modes, group selects, DOS settings and a spread of page values.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    localparam int PAGE_W = 8;

    typedef enum logic [1:0] {
        WM_RAM_MIX  = 2'b00,
        WM_ROM_DOS  = 2'b01,
        WM_RAM_FULL = 2'b10,
        WM_ROM_FULL = 2'b11
    } win_mode_e;

    typedef struct packed {
        win_mode_e          mode;
        logic [PAGE_W-1:0]  page;
    } slot_t;

    localparam int SLOT_W = $bits(slot_t);

    typedef enum logic [0:0] {
        MS_BOOT  = 1'b0,
        MS_PAGED = 1'b1
    } map_state_e;

endpackage

// File: rtl/mapper_regbank.sv
module mapper_regbank
    import mapper_pkg::*;
#(
    parameter int N_WIN = 4,
    localparam int N_SLOT = 2 * N_WIN,
    localparam int IDX_W = $clog2(N_SLOT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    slot_wr,
    input  logic [IDX_W-1:0]        slot_idx,
    input  logic [SLOT_W-1:0]       slot_wdata,
    input  logic                    leg_wr,
    input  logic [PAGE_W-1:0]       leg_wdata,
    input  logic                    ctl_wr,
    input  logic [1:0]              ctl_wdata,
    input  logic                    dos_req,
    output slot_t [N_WIN-1:0]       win_slot,
    output logic [2:0]              leg_lo,
    output logic                    dos_flag,
    output logic                    paging_on
);

    slot_t [N_SLOT-1:0] slot_q;
    logic [PAGE_W-1:0]  leg_q;
    logic               dos_follow_q;
    map_state_e         state_q, state_d;
    logic               armed_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MS_BOOT;
        else        state_q <= state_d;
    end

    // next-state logic: T_ENABLE / T_DISABLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_BOOT:  if (ctl_wr && ctl_wdata[0])  state_d = MS_PAGED;
            MS_PAGED: if (ctl_wr && !ctl_wdata[0]) state_d = MS_BOOT;
            default:  state_d = MS_BOOT;
        endcase
    end

    // register file
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q       <= '0;
            leg_q        <= '0;
            dos_follow_q <= 1'b0;
            armed_q      <= 1'b0;
        end else begin
            armed_q <= 1'b1;
            if (slot_wr) slot_q[slot_idx] <= slot_t'(slot_wdata);
            if (leg_wr)  leg_q <= leg_wdata;
            if (ctl_wr)  dos_follow_q <= ctl_wdata[1];
        end
    end

    // outputs: group selection by legacy bit 4
    always_comb begin
        for (int w = 0; w < N_WIN; w++) begin
            win_slot[w] = leg_q[4] ? slot_q[N_WIN + w] : slot_q[w];
        end
        leg_lo    = leg_q[2:0];
        dos_flag  = dos_follow_q ? dos_req : 1'b1;
        paging_on = (state_q == MS_PAGED);
    end

    // R1: reset contents seen at the first edge after reset
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> (slot_q == '0 && leg_q == '0 && !dos_follow_q && state_q == MS_BOOT));

    // R11: slots change only under their strobe
    a_r11_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(slot_wr)) |-> $stable(slot_q));

    // R11: legacy byte changes only under its strobe
    a_r11_leg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(leg_wr)) |-> $stable(leg_q));

endmodule

// File: rtl/mapper_win_decode.sv
module mapper_win_decode
    import mapper_pkg::*;
#(
    parameter int RAM_PAGE_BITS = 6,
    parameter int ROM_PAGE_BITS = 5,
    localparam logic [PAGE_W-1:0] RAM_MASK = PAGE_W'((1 << RAM_PAGE_BITS) - 1),
    localparam logic [PAGE_W-1:0] ROM_MASK = PAGE_W'((1 << ROM_PAGE_BITS) - 1)
) (
    input  slot_t              slot,
    input  logic [2:0]         leg_lo,
    input  logic               dos_flag,
    input  logic               paging_on,
    output logic [PAGE_W-1:0]  page,
    output logic               rom,
    output logic               we
);

    logic [PAGE_W-1:0] raw;
    logic              raw_rom;

    always_comb begin
        raw     = '0;
        raw_rom = 1'b1;
        unique case (slot.mode)
            WM_RAM_MIX: begin
                raw     = {slot.page[PAGE_W-1:3], leg_lo};
                raw_rom = 1'b0;
            end
            WM_ROM_DOS: begin
                raw     = {slot.page[PAGE_W-1:1], dos_flag};
                raw_rom = 1'b1;
            end
            WM_RAM_FULL: begin
                raw     = slot.page;
                raw_rom = 1'b0;
            end
            WM_ROM_FULL: begin
                raw     = slot.page;
                raw_rom = 1'b1;
            end
            default: begin
                raw     = '0;
                raw_rom = 1'b1;
            end
        endcase
    end

    always_comb begin
        if (!paging_on) begin
            page = ROM_MASK;
            rom  = 1'b1;
        end else begin
            page = raw & (raw_rom ? ROM_MASK : RAM_MASK);
            rom  = raw_rom;
        end
        // write permission derived from the mode encoding (bit 0 = ROM)
        we = paging_on & ~slot.mode[0];
    end

endmodule

// File: rtl/page_mapper.sv
module page_mapper
    import mapper_pkg::*;
#(
    parameter int RAM_PAGE_BITS = 6,
    parameter int ROM_PAGE_BITS = 5,
    parameter int N_WIN = 4,
    localparam int N_SLOT = 2 * N_WIN,
    localparam int IDX_W = $clog2(N_SLOT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      slot_wr,
    input  logic [IDX_W-1:0]          slot_idx,
    input  logic [SLOT_W-1:0]         slot_wdata,
    input  logic                      leg_wr,
    input  logic [PAGE_W-1:0]         leg_wdata,
    input  logic                      ctl_wr,
    input  logic [1:0]                ctl_wdata,
    input  logic                      dos_req,
    output logic [N_WIN*PAGE_W-1:0]   win_page,
    output logic [N_WIN-1:0]          win_rom,
    output logic [N_WIN-1:0]          win_we
);

    localparam logic [PAGE_W-1:0] ROM_LAST = PAGE_W'((1 << ROM_PAGE_BITS) - 1);

    slot_t [N_WIN-1:0] win_slot;
    logic [2:0]        leg_lo;
    logic              dos_flag;
    logic              paging_on;

    mapper_regbank #(.N_WIN(N_WIN)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_wr    (slot_wr),
        .slot_idx   (slot_idx),
        .slot_wdata (slot_wdata),
        .leg_wr     (leg_wr),
        .leg_wdata  (leg_wdata),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .dos_req    (dos_req),
        .win_slot   (win_slot),
        .leg_lo     (leg_lo),
        .dos_flag   (dos_flag),
        .paging_on  (paging_on)
    );

    for (genvar w = 0; w < N_WIN; w++) begin : g_win
        mapper_win_decode #(
            .RAM_PAGE_BITS (RAM_PAGE_BITS),
            .ROM_PAGE_BITS (ROM_PAGE_BITS)
        ) u_dec (
            .slot      (win_slot[w]),
            .leg_lo    (leg_lo),
            .dos_flag  (dos_flag),
            .paging_on (paging_on),
            .page      (win_page[w*PAGE_W +: PAGE_W]),
            .rom       (win_rom[w]),
            .we        (win_we[w])
        );

        // R10: page never exceeds the size of its memory
        a_r10_page_masked: assert property (@(posedge clk) disable iff (!rst_n)
            win_rom[w] ? ((win_page[w*PAGE_W +: PAGE_W] >> ROM_PAGE_BITS) == 0)
                       : ((win_page[w*PAGE_W +: PAGE_W] >> RAM_PAGE_BITS) == 0));

        // R2: paging off shows the last ROM page
        a_r2_boot_page: assert property (@(posedge clk) disable iff (!rst_n)
            !paging_on |-> (win_page[w*PAGE_W +: PAGE_W] == ROM_LAST));
    end

    // R9: a ROM window is never writable, a RAM window always is
    a_r9_rom_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (win_we == ~win_rom));

    // R2: paging off flags every window as ROM
    a_r2_boot_rom: assert property (@(posedge clk) disable iff (!rst_n)
        !paging_on |-> (&win_rom));

endmodule

// File: tb/test_page_mapper.sv
module test_page_mapper;

    localparam int CLK_PERIOD = 10;
    localparam int RAM_BITS = 6;
    localparam int ROM_BITS = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_wr = 1'b0;
    logic [2:0]  slot_idx = '0;
    logic [9:0]  slot_wdata = '0;
    logic        leg_wr = 1'b0;
    logic [7:0]  leg_wdata = '0;
    logic        ctl_wr = 1'b0;
    logic [1:0]  ctl_wdata = '0;
    logic        dos_req = 1'b0;
    logic [31:0] win_page;
    logic [3:0]  win_rom;
    logic [3:0]  win_we;

    int n_chk = 0;
    int n_bad = 0;

    // bench-side model of the written state
    logic [9:0] m_slot [8];
    logic [7:0] m_leg;
    logic [1:0] m_ctl;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_mapper i_page_mapper (
        .clk(clk), .rst_n(rst_n),
        .slot_wr(slot_wr), .slot_idx(slot_idx), .slot_wdata(slot_wdata),
        .leg_wr(leg_wr), .leg_wdata(leg_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .dos_req(dos_req),
        .win_page(win_page), .win_rom(win_rom), .win_we(win_we)
    );

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic do_slot(input int idx, input logic [9:0] d);
        @(negedge clk);
        slot_wr = 1'b1; slot_idx = 3'(idx); slot_wdata = d;
        @(negedge clk);
        slot_wr = 1'b0;
        m_slot[idx] = d;
    endtask

    task automatic do_leg(input logic [7:0] d);
        @(negedge clk);
        leg_wr = 1'b1; leg_wdata = d;
        @(negedge clk);
        leg_wr = 1'b0;
        m_leg = d;
    endtask

    task automatic do_ctl(input logic [1:0] d);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0;
        m_ctl = d;
    endtask

    // compare all windows against the model
    task automatic check_all(input string ctx);
        for (int w = 0; w < 4; w++) begin
            logic [9:0] s;
            logic [7:0] pg, e_pg, a_pg;
            logic       e_rom, dosf;
            string      tag;
            s    = m_leg[4] ? m_slot[w+4] : m_slot[w];   // R3 group select
            pg   = s[7:0];
            dosf = m_ctl[1] ? dos_req : 1'b1;            // R8
            if (!m_ctl[0]) begin
                e_pg = 8'((1 << ROM_BITS) - 1); e_rom = 1'b1; tag = "R2";
            end else begin
                case (s[9:8])
                    2'b00: begin e_pg = ({5'd0, m_leg[2:0]} | (pg & 8'hF8)) % (1 << RAM_BITS); e_rom = 1'b0; tag = "R4/R3/R10"; end
                    2'b01: begin e_pg = ((pg & 8'hFE) + {7'd0, dosf}) % (1 << ROM_BITS); e_rom = 1'b1; tag = "R5/R8/R10"; end
                    2'b10: begin e_pg = pg % (1 << RAM_BITS); e_rom = 1'b0; tag = "R6/R10"; end
                    default: begin e_pg = pg % (1 << ROM_BITS); e_rom = 1'b1; tag = "R7/R10"; end
                endcase
            end
            a_pg = win_page[w*8 +: 8];
            n_chk++;
            if (a_pg !== e_pg || win_rom[w] !== e_rom || win_we[w] !== !e_rom) begin
                n_bad++;
                $display("FAIL %s/R9 %s win%0d: actual page=%0d rom=%b we=%b expected page=%0d rom=%b we=%b",
                         tag, ctx, w, a_pg, win_rom[w], win_we[w], e_pg, e_rom, !e_rom);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_slot[i] = '0;
        m_leg = '0; m_ctl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, shown through the outputs
        check_all("R1 reset");

        // R2: slots written with paging off have no visible effect
        for (int j = 0; j < 8; j++) do_slot(j, 10'((j * 97 + 3) % 1024));
        do_leg(8'h13);
        check_all("R2 paging off");

        // R12: enable paging, then disable again
        do_ctl(2'b11);
        check_all("R12 enable");
        do_ctl(2'b10);
        check_all("R12 disable");

        // main sweep over modes, groups, DOS settings and page values
        for (int t = 0; t < 48; t++) begin
            for (int j = 0; j < 8; j++)
                do_slot(j, {2'((t + j) % 4), 8'((t * 37 + j * 53 + 11) % 256)});
            for (int c = 0; c < 8; c++) begin
                do_leg(8'(((t * 13 + c * 5) & 8'hEF) | ((c & 1) << 4)));   // R3 both groups
                @(negedge clk);
                dos_req = c[2];
                do_ctl({c[1], 1'b1});
                check_all("sweep");
                // R8: flip dos_req alone and compare after settling
                dos_req = ~dos_req;
                #1;
                check_all("R8 dos toggle");
            end
        end

        // R11: data without strobes leaves outputs unchanged
        @(negedge clk);
        slot_idx = 3'd0; slot_wdata = 10'h3FF; leg_wdata = 8'hFF; ctl_wdata = 2'b00;
        repeat (2) @(negedge clk);
        check_all("R11 no strobe");

        // R2: final disable restores boot mapping
        do_ctl(2'b00);
        check_all("R2 final");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule